// File: doc/BRIEF.md
# Core Clock Control Register with Masked Writes

This block is the control register and integer divider for one core clock. The 16-bit register holds two fields. A source-select field picks between the main parent (the PLL) and an alternate parent. A divider field holds a value n, and the selected parent is divided by n+1. Every 32-bit write carries its own per-bit enable in the upper half-word. Software or a hardware sequencer can therefore change any subset of bits in one transaction, with no read-modify-write. A single write can also move the source and the divider together.

Each parent clock appears in the block's own clock domain as a tick input. The divided clock leaves the block as a one-cycle enable pulse, once every n+1 ticks of the selected parent. Register contents do not reach the divider straight away. The divider takes the selector and the divider value as one pair at the next divide boundary, so the output never runs on a new selector with an old divider, or the other way round. The block also reports the divide ratio it is using, so a bench can work out the output rate from the parent rate.

Top module: `coreclk_ctl`

## Requirements
- R1: After reset the register reads 0x0040, with the selector field (bits 7:6) equal to 2'b01 (main parent) and the divider field (bits 4:0) equal to zero. The outputs report the main parent and a divide ratio of 1.
- R2: On a write, data bit i (i = 0..15) takes wr_data[i] only when wr_data[16+i] is 1. Otherwise it keeps its value. A write whose upper half is zero changes nothing.
- R3: rd_data[15:0] shows the register contents from the cycle after a write. rd_data[31:16] always reads zero.
- R4: With an active divider value n, clk_en pulses for one cycle on every (n+1)-th tick of the selected parent and stays low in all other cycles.
- R5: Selector value 2'b10 takes alt_tick as the parent. Every other selector value takes main_tick.
- R6: core_sel and div_ratio change only in a cycle where clk_en is high. They take the selector and divider fields of the same register state, so both change together.
- R7: div_ratio equals core_div + 1 and is never zero. Register changes made between two boundaries take effect at the next boundary, and the values used are those the register held when that boundary fired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Bits 31:16 per-bit enable, bits 15:0 data |
| rd_data | output | 32 | Readback, upper half zero |
| main_tick | input | 1 | One tick per main-parent clock cycle |
| alt_tick | input | 1 | One tick per alternate-parent clock cycle |
| core_sel | output | 2 | Active parent selector |
| core_div | output | 5 | Active divider value n |
| div_ratio | output | 6 | Active divide ratio n+1 |
| clk_en | output | 1 | Divided clock enable pulse |

## Verification
Directed writes cover three cases: a mask that covers only the selector bits, an all-zero mask, and a single write that changes both fields. Together they separate a correct per-bit masked update from a whole-word write and from a write that ignores the mask. Random writes then use random masks, with the two parent tick streams running at different densities. A cycle-accurate reference model is compared against the outputs in every cycle. The differing tick streams expose an inverted selector. Random divider values up to the maximum check the pulse period and show whether an update lands at the boundary or early.

// File: rtl/coreclk_pkg.sv
package coreclk_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/coreclk_maskreg.sv
module coreclk_maskreg
  import coreclk_pkg::*;
#(
  parameter half_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_word,
  output half_t q
);
  half_t en_bits;
  half_t dat_bits;
  assign en_bits  = wr_word[WORD_W-1:HALF_W];
  assign dat_bits = wr_word[HALF_W-1:0];

  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[b] <= RST_VAL[b];
      else if (wr_en && en_bits[b])
        q[b] <= dat_bits[b];
    end
  end
endmodule

// File: rtl/coreclk_fields.sv
module coreclk_fields
  import coreclk_pkg::*;
#(
  parameter int DIV_SHIFT = 0,
  parameter int DIV_W     = 5,
  parameter int SEL_SHIFT = 6,
  parameter int SEL_W     = 2
) (
  input  half_t             regq,
  output logic [DIV_W-1:0]  div_f,
  output logic [SEL_W-1:0]  sel_f
);
  assign div_f = regq[DIV_SHIFT +: DIV_W];
  assign sel_f = regq[SEL_SHIFT +: SEL_W];
endmodule

// File: rtl/coreclk_divider.sv
module coreclk_divider #(
  parameter int DIV_W = 5,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] SEL_MAIN = 2'b01,
  parameter logic [SEL_W-1:0] SEL_ALT  = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic             alt_tick,
  input  logic [DIV_W-1:0] div_f,
  input  logic [SEL_W-1:0] sel_f,
  output logic [DIV_W-1:0] act_div,
  output logic [SEL_W-1:0] act_sel,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt;
  logic             src_tick;
  logic             at_edge;

  assign src_tick = (act_sel == SEL_ALT) ? alt_tick : main_tick;
  assign at_edge  = src_tick && (cnt == act_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_div <= '0;
      act_sel <= SEL_MAIN;
      pulse   <= 1'b0;
    end else begin
      pulse <= at_edge;
      if (at_edge) begin
        cnt     <= '0;
        act_div <= div_f;
        act_sel <= sel_f;
      end else if (src_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/coreclk_ctl.sv
module coreclk_ctl
  import coreclk_pkg::*;
#(
  parameter int DIV_SHIFT = 0,
  parameter int DIV_W     = 5,
  parameter int SEL_SHIFT = 6,
  parameter int SEL_W     = 2,
  parameter logic [SEL_W-1:0] SEL_MAIN = 2'b01,
  parameter logic [SEL_W-1:0] SEL_ALT  = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             main_tick,
  input  logic             alt_tick,
  output logic [SEL_W-1:0] core_sel,
  output logic [DIV_W-1:0] core_div,
  output logic [DIV_W:0]   div_ratio,
  output logic             clk_en
);
  localparam half_t RST_WORD = half_t'(SEL_MAIN) << SEL_SHIFT;

  half_t            regq;
  logic [DIV_W-1:0] div_f;
  logic [SEL_W-1:0] sel_f;

  coreclk_maskreg #(.RST_VAL(RST_WORD)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_data), .q(regq)
  );

  coreclk_fields #(
    .DIV_SHIFT(DIV_SHIFT), .DIV_W(DIV_W), .SEL_SHIFT(SEL_SHIFT), .SEL_W(SEL_W)
  ) u_fld (
    .regq(regq), .div_f(div_f), .sel_f(sel_f)
  );

  coreclk_divider #(
    .DIV_W(DIV_W), .SEL_W(SEL_W), .SEL_MAIN(SEL_MAIN), .SEL_ALT(SEL_ALT)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .alt_tick(alt_tick),
    .div_f(div_f), .sel_f(sel_f), .act_div(core_div), .act_sel(core_sel),
    .pulse(clk_en)
  );

  assign rd_data   = {{HALF_W{1'b0}}, regq};
  assign div_ratio = {1'b0, core_div} + 1'b1;
endmodule

// File: rtl/coreclk_ctl_chk.sv
module coreclk_ctl_chk #(
  parameter int DIV_W = 5,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             main_tick,
  input logic             alt_tick,
  input logic [SEL_W-1:0] core_sel,
  input logic [DIV_W:0]   div_ratio,
  input logic             clk_en
);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0);

  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:16] == 16'h0) |=> $stable(rd_data));

  assert_unmasked_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data[15:0] & ~$past(wr_data[31:16])) ==
               ($past(rd_data[15:0]) & ~$past(wr_data[31:16]))));

  assert_pair_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_ratio) || !$stable(core_sel)) |-> clk_en);

  assert_pulse_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> $past(main_tick || alt_tick));

  assert_ratio_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_ratio != '0);
endmodule

bind coreclk_ctl coreclk_ctl_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .main_tick(main_tick), .alt_tick(alt_tick),
  .core_sel(core_sel), .div_ratio(div_ratio), .clk_en(clk_en)
);

// File: tb/sim_coreclk_ctl.sv
module sim_coreclk_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        main_tick = 1'b0;
  logic        alt_tick = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  core_sel;
  logic [4:0]  core_div;
  logic [5:0]  div_ratio;
  logic        clk_en;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coreclk_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .main_tick(main_tick), .alt_tick(alt_tick),
    .core_sel(core_sel), .core_div(core_div), .div_ratio(div_ratio),
    .clk_en(clk_en)
  );

  // reference model built from the requirements
  logic [15:0] m_reg;
  logic [4:0]  m_cnt, m_adiv;
  logic [1:0]  m_asel;
  logic        m_en;

  function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg <= 16'h0040; m_cnt <= '0; m_adiv <= '0; m_asel <= 2'b01; m_en <= 1'b0;
    end else begin
      if ((m_asel == 2'b10) ? alt_tick : main_tick) begin
        if (m_cnt == m_adiv) begin
          m_en <= 1'b1; m_cnt <= '0;
          m_adiv <= m_reg[4:0]; m_asel <= m_reg[7:6];
        end else begin
          m_en <= 1'b0; m_cnt <= m_cnt + 5'd1;
        end
      end else m_en <= 1'b0;
      if (wr_en) m_reg <= masked(m_reg, wr_data);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 rd_data", rd_data, {16'h0, m_reg});
    chk("R4 clk_en", {31'h0, clk_en}, {31'h0, m_en});
    chk("R5/R6 core_sel", {30'h0, core_sel}, {30'h0, m_asel});
    chk("R7 div_ratio", {26'h0, div_ratio}, {26'h0, m_adiv} + 32'd1);
  endtask

  // drive at negedge after comparing
  task automatic step(input logic we, input logic [31:0] wd, input logic mt, input logic at);
    @(negedge clk);
    if (rst_n) compare_all();
    wr_en = we; wr_data = wd; main_tick = mt; alt_tick = at;
  endtask

  initial begin : watchdog
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset rd", rd_data, 32'h0000_0040);
    chk("R1 reset sel", {30'h0, core_sel}, 32'h1);
    chk("R1 reset ratio", {26'h0, div_ratio}, 32'h1);
    // R2 mask covering only selector bits: alt, divider bits untouched
    step(1'b1, 32'h00C0_00BF, 1'b0, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R2 sel-only mask", rd_data, 32'h0000_0080);
    // R2 empty mask: nothing changes
    step(1'b1, 32'h0000_FFFF, 1'b0, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R2 empty mask", rd_data, 32'h0000_0080);
    // R6 one write moves both fields; only main ticking, boundary on main
    step(1'b1, 32'h00DF_0043, 1'b0, 1'b0);
    step(1'b0, 32'h0, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R6 joint sel", {30'h0, core_sel}, 32'h1);
    chk("R6 joint ratio", {26'h0, div_ratio}, 32'h4);
    // R4 period 4 on main, alt ticks ignored (R5)
    for (int k = 0; k < 12; k++) step(1'b0, 32'h0, 1'b1, 1'b1);
    // R7 max divider
    step(1'b1, 32'h001F_001F, 1'b1, 1'b0);
    for (int k = 0; k < 80; k++) step(1'b0, 32'h0, 1'b1, 1'b0);
    chk("R7 max ratio", {26'h0, div_ratio}, 32'd32);
    // random phase
    for (int k = 0; k < NRAND; k++) begin
      logic we;
      logic [31:0] wd;
      we = ($urandom % 16) == 0;
      wd = $urandom;
      if (($urandom % 4) == 0) wd[15:0] = {8'h00, wd[7] ? 2'b10 : 2'b01, wd[5:0]};
      step(we, wd, ($urandom % 3) != 0, ($urandom % 5) == 0);
    end
    step(1'b0, 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule